// File: doc/BRIEF.md
# Flash Busy Timer and Status Reporter

This block stands in for the self-timed engine of a byte-wide NOR flash. A command decoder elsewhere issues a one-cycle start pulse for a byte program, a sector erase or a whole-array erase. For a program it also supplies the byte being written. For an erase of one sector it supplies the sector number. The block counts the operation out in clock cycles and holds a busy flag for that time. When the operation ends it raises a one-cycle done pulse. Each duration is a parameter, so simulation can use short values.

A whole-array erase is not one long interval. The block walks the sectors from the lowest number to the highest and spends one sector-erase time on each. It publishes the sector it is working on, so the storage model can clear that sector.

Any read while busy returns a status byte in place of array data:
- Bit 7 is the polling bit. For a program it is the complement of the written byte's top bit. For any erase it is 0, because erased cells read as ones.
- Bit 6 is the toggle bit. It changes on every read made while busy.

Once the block is idle again, reads pass the array data straight through.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, busy, done and the toggle bit are 0, and the block is idle.
- R2: A program start taken while idle makes busy high from the next cycle for exactly PROG_CYCLES cycles.
- R3: A sector erase start taken while idle makes busy high for exactly SECT_CYCLES cycles. During that time erase_sector equals the sect_sel value captured at the start.
- R4: done is high for exactly one cycle: the first cycle in which busy is low after an operation.
- R5: While a program is busy, rd_data[7] is the complement of bit 7 of the prog_data captured at the start, and rd_data[5:0] is zero.
- R6: While busy, rd_data[6] shows the toggle bit, which is 0 after reset and inverts after each cycle in which rd_strobe is high. While idle, the toggle bit never changes.
- R7: While any erase is busy, rd_data[7] is 0 and rd_data[5:0] is zero.
- R8: While idle, rd_data equals array_data.
- R9: A whole-array erase is busy for NUM_SECTORS × SECT_CYCLES cycles. erase_sector starts at 0 and steps up by one after each SECT_CYCLES cycles.
- R10: Start pulses that arrive while busy are ignored. This includes a program attempt during an erase. The duration, the operation, the sector and the polling bit stay unchanged.
- R11: When several starts arrive together while idle, the whole-array erase wins over the sector erase, and the sector erase wins over the program.
- R12: A start given in the cycle where done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | One-cycle byte program start |
| start_sect | input | 1 | One-cycle sector erase start |
| start_chip | input | 1 | One-cycle whole-array erase start |
| prog_data | input | 8 | Byte being programmed, captured with start_prog |
| sect_sel | input | SECT_W | Sector to erase, captured with start_sect |
| rd_strobe | input | 1 | High for one cycle per host read |
| array_data | input | 8 | True array data for the addressed byte |
| busy | output | 1 | Internal operation in progress |
| done | output | 1 | One-cycle pulse when busy falls |
| erase_sector | output | SECT_W | Sector currently being erased |
| rd_data | output | 8 | Read data: status while busy, array data while idle |

## Verification
Busy is due one clock edge after a start is taken. It stays high for the full count, and done is due in the very next cycle after busy falls. rd_data is combinational from registered state, so the polling bit and the array passthrough hold in the same cycle as the read. The toggle bit inverts only at the edge that ends a read cycle. The bench drives every input on the falling edge and samples one time unit later. It counts busy cycles one per falling edge and compares the count with the parameter products. It keeps its own model of the toggle bit and updates that model only after each busy read.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2
    } fbs_op_e;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
endpackage

// File: rtl/fbs_cycle_timer.sv
module fbs_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = run && (cnt_q == '0);

    // R2: a running, non-reloaded count drops by exactly one per cycle
    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fbs_status.sv
module fbs_status
    import fbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       poll_from_data,
    input  logic       poll_src,
    input  logic       rd_strobe,
    input  logic [7:0] array_data,
    output logic [7:0] rd_data
);
    logic tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (busy && rd_strobe)
            tog_d = ~tog_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_d;
    end

    always_comb begin
        rd_data = array_data;
        if (busy) begin
            rd_data           = 8'h00;
            rd_data[POLL_BIT] = poll_from_data ? ~poll_src : 1'b0;
            rd_data[TOG_BIT]  = tog_q;
        end
    end

    // R6: each busy read inverts the toggle bit
    a_r6_tog_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_strobe) |=> (tog_q != $past(tog_q)));
    // R6: toggle bit frozen while idle
    a_r6_tog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog_q));
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
    import fbs_pkg::*;
#(
    parameter  int PROG_CYCLES = 20,
    parameter  int SECT_CYCLES = 40,
    parameter  int NUM_SECTORS = 256,
    localparam int SECT_W      = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_sect,
    input  logic              start_chip,
    input  logic [7:0]        prog_data,
    input  logic [SECT_W-1:0] sect_sel,
    input  logic              rd_strobe,
    input  logic [7:0]        array_data,
    output logic              busy,
    output logic              done,
    output logic [SECT_W-1:0] erase_sector,
    output logic [7:0]        rd_data
);
    localparam int MAX_CYC = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0]  PROG_LOAD = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0]  SECT_LOAD = CNT_W'(SECT_CYCLES - 1);
    localparam logic [SECT_W-1:0] LAST_SECT = SECT_W'(NUM_SECTORS - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        fbs_op_e           op;
        logic              pol;
        logic [SECT_W-1:0] sector;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = SECT_LOAD;
        if (!ctl_q.busy) begin
            if (start_chip) begin
                ctl_d.busy   = 1'b1;
                ctl_d.op     = OP_CHIP;
                ctl_d.sector = '0;
                tmr_load     = 1'b1;
            end else if (start_sect) begin
                ctl_d.busy   = 1'b1;
                ctl_d.op     = OP_SECT;
                ctl_d.sector = sect_sel;
                tmr_load     = 1'b1;
            end else if (start_prog) begin
                ctl_d.busy   = 1'b1;
                ctl_d.op     = OP_PROG;
                ctl_d.pol    = prog_data[POLL_BIT];
                tmr_load     = 1'b1;
                tmr_val      = PROG_LOAD;
            end
        end else if (tmr_expire) begin
            if (ctl_q.op == OP_CHIP && ctl_q.sector != LAST_SECT) begin
                ctl_d.sector = ctl_q.sector + 1'b1;
                tmr_load     = 1'b1;
            end else begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{busy: 1'b0, done: 1'b0, op: OP_PROG, pol: 1'b0, sector: '0};
        else        ctl_q <= ctl_d;
    end

    fbs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (ctl_q.busy),
        .expire   (tmr_expire)
    );

    fbs_status u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy           (ctl_q.busy),
        .poll_from_data (ctl_q.op == OP_PROG),
        .poll_src       (ctl_q.pol),
        .rd_strobe      (rd_strobe),
        .array_data     (array_data),
        .rd_data        (rd_data)
    );

    assign busy         = ctl_q.busy;
    assign done         = ctl_q.done;
    assign erase_sector = ctl_q.sector;

    // R2: busy holds until the timer runs out
    a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && !tmr_expire) |=> ctl_q.busy);
    // R4: done lasts a single cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done);
    // R4: done only right after busy falls
    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> (!ctl_q.busy && $past(ctl_q.busy)));
    // R10: operation and polling source frozen while busy
    a_r10_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && !tmr_expire) |=> ($stable(ctl_q.op) && $stable(ctl_q.pol) && $stable(ctl_q.sector)));
    // R9: whole-array erase steps to the next sector at each expiry
    a_r9_sector_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && tmr_expire && ctl_q.op == OP_CHIP && ctl_q.sector != LAST_SECT)
            |=> (ctl_q.busy && ctl_q.sector == $past(ctl_q.sector) + 1'b1));
endmodule

// File: tb/flash_busy_status_bench.sv
module flash_busy_status_bench;
    localparam int P = 20;
    localparam int S = 40;
    localparam int N = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_prog = 1'b0, start_sect = 1'b0, start_chip = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic [7:0] sect_sel = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = 8'h5A;
    logic       busy, done;
    logic [7:0] erase_sector;
    logic [7:0] rd_data;

    int  checks = 0;
    int  errors = 0;
    logic exp_tog = 1'b0;

    always #4 clk = ~clk;

    flash_busy_status #(.PROG_CYCLES(P), .SECT_CYCLES(S), .NUM_SECTORS(N)) u_flash_busy_status (
        .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_sect(start_sect),
        .start_chip(start_chip), .prog_data(prog_data), .sect_sel(sect_sel),
        .rd_strobe(rd_strobe), .array_data(array_data), .busy(busy), .done(done),
        .erase_sector(erase_sector), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One operation: starts = {chip, sect, prog}
    task automatic run_op(input logic [2:0] starts, input logic [7:0] data, input logic [7:0] sect,
                          input int nreads, input bit intrude, input int exp_len, input bit exp_b7,
                          input bit chipmode, input bit sectmode, input string tag);
        int n;
        start_chip = starts[2];
        start_sect = starts[1];
        start_prog = starts[0];
        prog_data  = data;
        sect_sel   = sect;
        @(negedge clk);
        start_chip = 1'b0; start_sect = 1'b0; start_prog = 1'b0;
        chk({tag, " R12 busy after start"}, busy, 1);
        chk({tag, " R4 done low while busy"}, done, 0);
        n = 0;
        while (busy && n < exp_len + 5) begin
            if (intrude && n == 2) begin
                start_prog = 1'b1; start_chip = 1'b1; start_sect = 1'b1;
                prog_data = ~data; sect_sel = sect + 8'd3;
            end
            if (n < nreads) begin
                rd_strobe = 1'b1;
                #1;
                chk({tag, " status byte"}, rd_data, {exp_b7, exp_tog, 6'b0});
                exp_tog = ~exp_tog;
            end
            if (chipmode && (n % S) == 0) chk("R9 erase_sector", erase_sector, n / S);
            if (sectmode && n == exp_len - 1) chk("R3 erase_sector", erase_sector, sect);
            n++;
            @(negedge clk);
            rd_strobe = 1'b0;
            start_prog = 1'b0; start_chip = 1'b0; start_sect = 1'b0;
        end
        chk({tag, " busy length"}, n, exp_len);
        chk("R4 done at end", done, 1);
    endtask

    task automatic idle_read(input logic [7:0] val);
        array_data = val;
        rd_strobe  = 1'b1;
        #1;
        chk("R8 idle passthrough", rd_data, val);
        @(negedge clk);
        rd_strobe = 1'b0;
        #1;
        chk("R6 toggle frozen idle", rd_data, val);
    endtask

    task automatic t_reset();
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R8 reset passthrough", rd_data, 8'h5A);
    endtask

    task automatic t_program();
        run_op(3'b001, 8'hA5, 8'h00, 3, 1'b0, P, 1'b0, 1'b0, 1'b0, "R2 R5 R6 prog");
        @(negedge clk);
        chk("R4 done one cycle", done, 0);
        idle_read(8'h3C);
        idle_read(8'hC3);
    endtask

    task automatic t_program_intrude_then_sector();
        run_op(3'b001, 8'h12, 8'h00, 5, 1'b1, P, 1'b1, 1'b0, 1'b0, "R10 R5 prog");
        // R12: next start issued in the done cycle
        run_op(3'b010, 8'h00, 8'd77, 2, 1'b1, S, 1'b0, 1'b0, 1'b1, "R3 R7 R10 sect");
        @(negedge clk);
        idle_read(8'h00);
    endtask

    task automatic t_prio_sect_prog();
        run_op(3'b011, 8'h80, 8'd9, 1, 1'b0, S, 1'b0, 1'b0, 1'b1, "R11 sect over prog");
        @(negedge clk);
    endtask

    task automatic t_chip();
        run_op(3'b100, 8'h00, 8'h00, 4, 1'b1, N * S, 1'b0, 1'b1, 1'b0, "R9 R7 chip");
        @(negedge clk);
        idle_read(8'hFF);
    endtask

    task automatic t_prio_all();
        run_op(3'b111, 8'hFF, 8'd5, 2, 1'b0, N * S, 1'b0, 1'b1, 1'b0, "R11 chip wins");
        @(negedge clk);
        idle_read(8'h69);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_program();
        t_program_intrude_then_sector();
        t_prio_sect_prog();
        t_chip();
        t_prio_all();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule